// File: doc/BRIEF.md
# Timebase Interval Timer

This block keeps a free-running binary counter that advances once for every cycle in which a prescaled enable pulse from the clock generator is high. Software chooses one of four counter bits as the interval tap. Each time that bit falls from 1 to 0, the block records an overflow in a sticky flag. While the flag and its enable are both set, the block drives a level interrupt request to the processor.

Software reaches the block through one 8-bit control register on a small bus: a select line, a write strobe, write data and read data. A write of 0 clears the sticky flag, and a write of 1 leaves it as it is. A second write-0 control bit returns the whole counter to zero, so software can start a fresh interval from a known point. That bit always reads back as 1.

Top module: `tbase_timer`

## Requirements
- R1: After reset, a selected read returns 0x04 and `irq` is low. The flag, the enable and the interval select are all 0.
- R2: Register bits 7:5 always read as 0, and writing them changes nothing.
- R3: The counter advances by one only in cycles with `tick_en` high. The flag (bit 4) sets on the clock edge at which the selected tap bit goes from 1 to 0. Select values 0, 1, 2 and 3 in bits 1:0 pick the taps `TAP0`, `TAP1`, `TAP2` and `TAP3`, which default to counter bits 12, 14, 16 and 19.
- R4: A write with bit 4 = 0 clears the flag. A write with bit 4 = 1 leaves the flag unchanged.
- R5: `irq` is high exactly while the flag and the interrupt enable (bit 3) are both 1.
- R6: A write with bit 2 = 0 sets the counter to zero on that edge. This overrides a tick in the same cycle, and it raises no overflow. A write with bit 2 = 1 does not touch the counter.
- R7: Bit 2 always reads as 1.
- R8: The enable (bit 3) and the interval select (bits 1:0) read back the values last written.
- R9: If an overflow and a write that clears the flag fall in the same cycle, the flag ends up set.
- R10: While `reg_sel` is low, `reg_rdata` is 0 and `reg_wr` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Prescaled count enable, one pulse per counter step |
| reg_sel | input | 1 | Selects the control register |
| reg_wr | input | 1 | Write strobe, acts only while selected |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not selected |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a software write that lands in exactly the cycle of a tap overflow. The counter is not visible at the ports, so the bench finds that cycle from its own model of the counter. It uses this to place a flag-clearing write on the overflow cycle (R9) and, separately, a counter-clear write on the overflow cycle (R6). It also clears the counter and then counts ticks up to the interrupt for every tap. This measures each interval exactly. A long random run with mixed tick, select and write traffic is then compared cycle by cycle against the model.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int FLAG_BIT = 4;
    localparam int IEN_BIT  = 3;
    localparam int CLR_BIT  = 2;
    localparam int NUM_TAPS = 4;
    localparam int SEL_W    = $clog2(NUM_TAPS);

    typedef struct packed {
        logic             flag;
        logic             ien;
        logic [SEL_W-1:0] isel;
    } ctrl_t;

endpackage

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/tbase_tap.sv
module tbase_tap
    import tbase_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int TAP0  = 12,
    parameter int TAP1  = 14,
    parameter int TAP2  = 16,
    parameter int TAP3  = 19
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] isel,
    output logic             evt
);

    logic [NUM_TAPS-1:0] tap_full;

    // A tap bit falls from 1 to 0 on the next increment exactly when it
    // and every bit below it are 1.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int TAP_BIT = (g == 0) ? TAP0 :
                                 (g == 1) ? TAP1 :
                                 (g == 2) ? TAP2 : TAP3;
        assign tap_full[g] = &cnt[TAP_BIT:0];
    end

    assign evt = tick & ~clr & tap_full[isel];

endmodule

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       wr,
    input  logic [4:0] wdata,
    input  logic       evt,
    output logic [SEL_W-1:0] isel,
    output logic       flag,
    output logic       clr_req,
    output logic       irq,
    output logic [7:0] rdata
);

    ctrl_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            regs_d.ien  = wdata[IEN_BIT];
            regs_d.isel = wdata[SEL_W-1:0];
            if (!wdata[FLAG_BIT]) begin
                regs_d.flag = 1'b0;
            end
        end
        // an overflow in the same cycle as a clearing write wins
        if (evt) begin
            regs_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign isel    = regs_q.isel;
    assign flag    = regs_q.flag;
    assign clr_req = wr & ~wdata[CLR_BIT];
    assign irq     = regs_q.flag & regs_q.ien;
    assign rdata   = rd_en ? {3'b000, regs_q.flag, regs_q.ien, 1'b1, regs_q.isel}
                           : 8'h00;

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int TAP0  = 12,
    parameter int TAP1  = 14,
    parameter int TAP2  = 16,
    parameter int TAP3  = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);

    logic             wr_acc;
    logic             clr_req;
    logic             ovf_evt;
    logic             ovf_flag;
    logic [SEL_W-1:0] isel;
    logic [CNT_W-1:0] cnt_val;
    logic             unused_wbits;

    assign wr_acc       = reg_sel & reg_wr;
    assign unused_wbits = ^reg_wdata[7:5];

    tbase_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .clr   (clr_req),
        .cnt   (cnt_val)
    );

    tbase_tap #(
        .CNT_W (CNT_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3)
    ) u_tap (
        .cnt   (cnt_val),
        .tick  (tick_en),
        .clr   (clr_req),
        .isel  (isel),
        .evt   (ovf_evt)
    );

    tbase_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (reg_sel),
        .wr      (wr_acc),
        .wdata   (reg_wdata[4:0]),
        .evt     (ovf_evt),
        .isel    (isel),
        .flag    (ovf_flag),
        .clr_req (clr_req),
        .irq     (irq),
        .rdata   (reg_rdata)
    );

endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             ovf_evt,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] cnt_val
);

    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> reg_rdata[7:5] == 3'b000);

    // R7
    clr_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> reg_rdata[2]);

    // R3
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(ovf_evt));

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_wdata[4] && !ovf_evt) |=> ovf_flag == $past(ovf_flag));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && !reg_wdata[2]) |=> cnt_val == '0);

endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ovf_evt   (ovf_evt),
    .ovf_flag  (ovf_flag),
    .cnt_val   (cnt_val)
);

// File: tb/tbase_timer_bench.sv
module tbase_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int taps[4] = '{3, 5, 7, 9};

    // behavioural reference state
    int m_cnt  = 0;
    int m_flag = 0;
    int m_ien  = 0;
    int m_sel  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tbase_timer #(
        .CNT_W (W),
        .TAP0  (3),
        .TAP1  (5),
        .TAP2  (7),
        .TAP3  (9)
    ) u_tbase_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit next_overflows();
        int nxt;
        int tap;
        tap = taps[m_sel];
        nxt = (m_cnt + 1) % (1 << W);
        return (((m_cnt >> tap) & 1) == 1) && (((nxt >> tap) & 1) == 0);
    endfunction

    // one clock: drive, update model at the edge, compare at the falling edge
    task automatic step(input bit s, input bit w, input logic [7:0] d, input bit t);
        bit wr;
        bit clr;
        bit ev;
        int exp_rd;
        reg_sel   = s;
        reg_wr    = w;
        reg_wdata = d;
        tick_en   = t;
        @(posedge clk);
        wr  = s && w;
        clr = wr && !d[2];
        ev  = t && !clr && next_overflows();
        if (clr) m_cnt = 0;
        else if (t) m_cnt = (m_cnt + 1) % (1 << W);
        if (wr) begin
            m_ien = d[3];
            m_sel = d[1:0];
            if (!d[4]) m_flag = 0;
        end
        if (ev) m_flag = 1;
        @(negedge clk);
        exp_rd = s ? ((m_flag << 4) | (m_ien << 3) | 4 | m_sel) : 0;
        check(irq == (m_flag && m_ien), "R5 irq level", irq, m_flag && m_ien);
        check(reg_rdata == exp_rd, "R8 R10 register read", reg_rdata, exp_rd);
    endtask

    task automatic idle_read();
        step(1'b1, 1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle_read();
        check(reg_rdata == 8'h04, "R1 reset read", reg_rdata, 8'h04);
        check(irq == 1'b0, "R1 reset irq", irq, 0);

        // R2 upper bits ignored, R4 writing 1 does not set the flag
        step(1'b1, 1'b1, 8'hFF, 1'b0);
        idle_read();
        check(reg_rdata == 8'h0F, "R2 R4 write all ones", reg_rdata, 8'h0F);

        // R8 read back enable and select
        step(1'b1, 1'b1, 8'h06, 1'b0);
        idle_read();
        check(reg_rdata == 8'h06, "R8 readback select", reg_rdata, 8'h06);

        // R10 write while not selected ignored
        step(1'b0, 1'b1, 8'h0D, 1'b0);
        check(reg_rdata == 8'h00, "R10 unselected read", reg_rdata, 0);
        idle_read();
        check(reg_rdata == 8'h06, "R10 unselected write ignored", reg_rdata, 8'h06);

        // R3 tap 0, enabled, 16 ticks from zero
        step(1'b1, 1'b1, 8'h08, 1'b0);           // clear counter, enable, select 0
        for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 8'h00, 1'b1);
        check(irq == 1'b0, "R3 no overflow before tap", irq, 0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        check(irq == 1'b1, "R3 R5 overflow at tap 0", irq, 1);

        // R4 write 1 to flag holds, write 0 clears
        step(1'b1, 1'b1, 8'hFC, 1'b0);
        check(reg_rdata[4] == 1'b1, "R4 flag held", reg_rdata[4], 1);
        step(1'b1, 1'b1, 8'h0C, 1'b0);
        check(reg_rdata[4] == 1'b0, "R4 flag cleared", reg_rdata[4], 0);
        check(irq == 1'b0, "R5 irq drops with flag", irq, 0);

        // R3 no progress without ticks
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 8'h00, 1'b0);
        check(irq == 1'b0, "R3 idle without tick", irq, 0);

        // R9 clearing write on the overflow cycle
        n = 0;
        while (!next_overflows() && n < 100) begin
            step(1'b0, 1'b0, 8'h00, 1'b1);
            n++;
        end
        step(1'b1, 1'b1, 8'h0C, 1'b1);
        check(reg_rdata[4] == 1'b1, "R9 set wins", reg_rdata[4], 1);
        step(1'b1, 1'b1, 8'h0C, 1'b0);

        // R6 counter clear on the overflow cycle suppresses the overflow
        n = 0;
        while (!next_overflows() && n < 100) begin
            step(1'b0, 1'b0, 8'h00, 1'b1);
            n++;
        end
        step(1'b1, 1'b1, 8'h08, 1'b1);
        check(reg_rdata[4] == 1'b0, "R6 clear blocks overflow", reg_rdata[4], 0);
        for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 8'h00, 1'b1);
        check(irq == 1'b0, "R6 counter restarted from zero", irq, 0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        check(irq == 1'b1, "R6 interval after clear", irq, 1);

        // R3 interval length for every tap
        for (int s = 0; s < 4; s++) begin
            step(1'b1, 1'b1, 8'h08 | 8'(s), 1'b0);   // clear flag and counter
            n = 0;
            while (!irq && n < 5000) begin
                step(1'b0, 1'b0, 8'h00, 1'b1);
                n++;
            end
            check(n == (1 << (taps[s] + 1)), "R3 tap interval", n, 1 << (taps[s] + 1));
        end

        // R7 clear bit reads one after writing zero to it
        step(1'b1, 1'b1, 8'h00, 1'b0);
        check(reg_rdata[2] == 1'b1, "R7 clear bit reads one", reg_rdata[2], 1);

        // mixed random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (($urandom % 8) != 0) d[2] = 1'b1;
            if (($urandom % 4) != 0) d[1] = 1'b0;
            step(($urandom % 3) == 0, ($urandom % 4) == 0, d, ($urandom % 4) != 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule